// File: doc/BRIEF.md
# Shared-Bus Arbiter with Idle Time-out Masking

This block grants a parallel shared bus to one of several requesting masters by fixed priority, with request 0 the highest. Once granted, a master keeps the bus for as long as it keeps requesting. A time-out monitor checks that the owner actually uses the bus. It counts clocks while the bus is idle, the grant is outstanding and no transaction start (FRAME) is seen. If the count reaches the window and the time-out is enabled, the grant is withdrawn on the next edge and a one-cycle pulse is raised.

An 8-bit control register sets the behaviour. Bit 7 enables the time-out. Bit 6 enables automatic masking. Bit 0 masks request 0. Bits 5:1 are reserved. When automatic masking is on and the master that timed out is request 0, bit 0 is set by hardware, so later requests from that master are ignored until software clears the bit.

The register is cleared only by the fundamental reset, which is active whenever either of two active-low reset inputs is low. A separate lighter reset clears the grant and the monitor but leaves the register as it is.

Top module: `bus_arb_tmo`

## Requirements
- R1: While `rst_a_n` or `rst_b_n` is low, and after either is released, `cfg_rdata` reads 8'h00, `gnt` is all zero and `tmo_pulse` is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` bits 7, 6 and 0 at the next edge. `cfg_rdata` bits 5:1 always read 0, whatever value is written to them.
- R3: `gnt` is one-hot or zero and is registered. With no grant held, the lowest-numbered effective request wins at the next edge. A held grant stays while its master keeps requesting, even if a higher-priority request arrives.
- R4: While bit 0 is 1, `req[0]` is treated as deasserted. It is neither granted nor kept in a grant.
- R5: With bit 7 at 0, no time-out occurs: a grant on an idle bus without FRAME stays for any number of cycles, and `tmo_pulse` stays 0.
- R6: With bit 7 at 1, after 16 consecutive cycles with `bus_idle`=1, a grant held and `frame_act`=0, the next edge clears `gnt` and raises `tmo_pulse` for exactly one cycle.
- R7: A cycle with `frame_act`=1 or `bus_idle`=0, or a grant change, restarts the 16-cycle window from zero.
- R8: With bits 7 and 6 set, a time-out of master 0 sets bit 0 at the same edge that removes the grant. A time-out of any other master leaves bit 0 unchanged.
- R9: If a register write and an automatic mask fall in the same cycle, bit 0 ends up 1. A later write of 0 to bit 0 lets `req[0]` be granted again.
- R10: After a time-out, the cycle with no grant is followed by normal re-arbitration among the unmasked requests, which may re-grant the same master.
- R11: Holding `sys_rst_n` low clears `gnt`, `tmo_pulse` and the window, but keeps the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_a_n | input | 1 | Fundamental reset source A, active low |
| rst_b_n | input | 1 | Fundamental reset source B, active low |
| sys_rst_n | input | 1 | Light synchronous reset of arbitration state, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| req | input | N_REQ | Request inputs, index 0 highest priority |
| bus_idle | input | 1 | Bus is idle |
| frame_act | input | 1 | Owner has asserted FRAME (transaction start), active high |
| gnt | output | N_REQ | One-hot grant |
| tmo_pulse | output | 1 | One-cycle time-out event flag |

## Verification
The hardest case to reach is a time-out of master 0 with automatic masking on, landing in the same cycle as a software write that clears bit 0. The bench first enables both time-out bits and grants request 0 on an idle bus with FRAME low. It then counts fifteen cycles from the grant and presents the conflicting write exactly in the sixteenth, so the time-out and the write meet at one edge. A second case restarts the window mid-count with a one-cycle FRAME and checks that the grant survives a full fresh window.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int CTRL_W    = 8;
  localparam int B_TMO_EN  = 7;
  localparam int B_AMASK   = 6;
  localparam int B_MASK0   = 0;

  typedef struct packed {
    logic tmo_en;
    logic amask_en;
    logic mask0;
  } bat_ctrl_t;

  // register image: reserved bits forced to zero
  function automatic logic [CTRL_W-1:0] ctrl_image(input bat_ctrl_t c);
    logic [CTRL_W-1:0] r;
    r = '0;
    r[B_TMO_EN] = c.tmo_en;
    r[B_AMASK]  = c.amask_en;
    r[B_MASK0]  = c.mask0;
    return r;
  endfunction

  // next control value: a hardware mask set outranks the write data
  function automatic bat_ctrl_t ctrl_next(input bat_ctrl_t cur, input logic we,
                                          input logic [CTRL_W-1:0] wd, input logic hw_set);
    bat_ctrl_t n;
    n = cur;
    if (we) begin
      n.tmo_en   = wd[B_TMO_EN];
      n.amask_en = wd[B_AMASK];
      n.mask0    = wd[B_MASK0];
    end
    if (hw_set) n.mask0 = 1'b1;
    return n;
  endfunction
endpackage

// File: rtl/bat_ctrl_reg.sv
module bat_ctrl_reg
  import bat_pkg::*;
(
  input  logic              clk,
  input  logic              frst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              hw_mask_set,
  output bat_ctrl_t         ctrl,
  output logic [CTRL_W-1:0] rdata
);
  bat_ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge frst_n) begin
    if (!frst_n) ctrl_q <= '0;
    else         ctrl_q <= ctrl_next(ctrl_q, cfg_we, cfg_wdata, hw_mask_set);
  end

  assign ctrl  = ctrl_q;
  assign rdata = ctrl_image(ctrl_q);

  AST_AUTOMASK_SET: assert property (@(posedge clk) disable iff (!frst_n)
    hw_mask_set |=> ctrl_q.mask0); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!frst_n)
    (cfg_we && !hw_mask_set) |=> (rdata == {$past(cfg_wdata[7:6]), 5'b0, $past(cfg_wdata[0])})); // R2
endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel #(
  parameter int N_REQ = 4
) (
  input  logic [N_REQ-1:0] req_eff,
  input  logic [N_REQ-1:0] gnt_q,
  input  logic             tmo_evt,
  output logic [N_REQ-1:0] gnt_nxt,
  output logic             gnt_chg
);
  always_comb begin
    gnt_nxt = '0;
    if (tmo_evt) begin
      gnt_nxt = '0;
    end else if (|(req_eff & gnt_q)) begin
      gnt_nxt = gnt_q;
    end else begin
      for (int i = N_REQ - 1; i >= 0; i--) begin
        if (req_eff[i]) begin
          gnt_nxt    = '0;
          gnt_nxt[i] = 1'b1;
        end
      end
    end
  end

  assign gnt_chg = (gnt_nxt != gnt_q);
endmodule

// File: rtl/bat_tmo_mon.sv
module bat_tmo_mon #(
  parameter int TMO_CLKS = 16
) (
  input  logic clk,
  input  logic frst_n,
  input  logic sys_rst_n,
  input  logic tmo_en,
  input  logic bus_idle,
  input  logic frame_act,
  input  logic gnt_held,
  input  logic gnt_chg,
  output logic counting,
  output logic tmo_evt
);
  localparam int CNT_W = (TMO_CLKS > 1) ? $clog2(TMO_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign counting = bus_idle && gnt_held && !frame_act;
  assign tmo_evt  = tmo_en && counting && (cnt_q == LAST);

  always_ff @(posedge clk or negedge frst_n) begin
    if (!frst_n)                   cnt_q <= '0;
    else if (!sys_rst_n)           cnt_q <= '0;
    else if (gnt_chg || !counting) cnt_q <= '0;
    else if (cnt_q != LAST)        cnt_q <= cnt_q + 1'b1;
  end

  AST_WINDOW_FULL: assert property (@(posedge clk) disable iff (!frst_n || !sys_rst_n)
    tmo_evt |-> $past(counting)); // R7
endmodule

// File: rtl/bus_arb_tmo.sv
module bus_arb_tmo
  import bat_pkg::*;
#(
  parameter int N_REQ    = 4,
  parameter int TMO_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst_a_n,
  input  logic              rst_b_n,
  input  logic              sys_rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  input  logic [N_REQ-1:0]  req,
  input  logic              bus_idle,
  input  logic              frame_act,
  output logic [N_REQ-1:0]  gnt,
  output logic              tmo_pulse
);
  logic             frst_n;
  bat_ctrl_t        ctrl;
  logic [N_REQ-1:0] req_eff, gnt_q, gnt_nxt;
  logic             gnt_chg, tmo_evt, counting, hw_mask_set, pulse_q;

  assign frst_n = rst_a_n & rst_b_n;

  always_comb begin
    req_eff    = req;
    req_eff[0] = req[0] & ~ctrl.mask0;
  end

  assign hw_mask_set = tmo_evt && ctrl.amask_en && gnt_q[0];

  bat_ctrl_reg u_reg (
    .clk        (clk),
    .frst_n     (frst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .hw_mask_set(hw_mask_set),
    .ctrl       (ctrl),
    .rdata      (cfg_rdata)
  );

  bat_prio_sel #(.N_REQ(N_REQ)) u_sel (
    .req_eff(req_eff),
    .gnt_q  (gnt_q),
    .tmo_evt(tmo_evt),
    .gnt_nxt(gnt_nxt),
    .gnt_chg(gnt_chg)
  );

  bat_tmo_mon #(.TMO_CLKS(TMO_CLKS)) u_mon (
    .clk      (clk),
    .frst_n   (frst_n),
    .sys_rst_n(sys_rst_n),
    .tmo_en   (ctrl.tmo_en),
    .bus_idle (bus_idle),
    .frame_act(frame_act),
    .gnt_held (|gnt_q),
    .gnt_chg  (gnt_chg),
    .counting (counting),
    .tmo_evt  (tmo_evt)
  );

  always_ff @(posedge clk or negedge frst_n) begin
    if (!frst_n) begin
      gnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!sys_rst_n) begin
      gnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      gnt_q   <= gnt_nxt;
      pulse_q <= tmo_evt;
    end
  end

  assign gnt       = gnt_q;
  assign tmo_pulse = pulse_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!frst_n)
    $onehot0(gnt_q)); // R3
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!frst_n)
    ctrl.mask0 |=> !gnt_q[0]); // R4
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!frst_n)
    tmo_pulse |-> $past(ctrl.tmo_en)); // R5
  AST_TMO_DROPS_GNT: assert property (@(posedge clk) disable iff (!frst_n || !sys_rst_n)
    tmo_evt |=> (gnt_q == '0) && tmo_pulse); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!frst_n)
    tmo_pulse |=> !tmo_pulse); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!frst_n)
    $past(cfg_we) |-> (cfg_rdata[5:1] == 5'b0)); // R2
endmodule

// File: tb/bus_arb_tmo_test.sv
`timescale 1ns/1ps
module bus_arb_tmo_test;
  logic       clk = 1'b0;
  logic       rst_a_n = 1'b0, rst_b_n = 1'b0, sys_rst_n = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic [3:0] req = 4'h0;
  logic       bus_idle = 1'b0, frame_act = 1'b0;
  logic [3:0] gnt;
  logic       tmo_pulse;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  bus_arb_tmo uut (
    .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .sys_rst_n(sys_rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req(req), .bus_idle(bus_idle), .frame_act(frame_act),
    .gnt(gnt), .tmo_pulse(tmo_pulse)
  );

  // {req[3:0], expected gnt[3:0]}: lowest index wins from an empty grant
  localparam logic [7:0] PVEC [7] = '{8'hF1, 8'hE2, 8'hC4, 8'h88, 8'h62, 8'hA2, 8'h00};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  // after the grant edge: 15 more cycles hold, the 16th edge drops it
  task automatic await_tmo(input string tag, input logic [3:0] owner);
    tick(15);
    chk({tag, " hold"}, {27'd0, tmo_pulse, gnt}, {27'd0, 1'b0, owner});
    tick(1);
    chk({tag, " drop"}, {27'd0, tmo_pulse, gnt}, 32'h10);
  endtask

  initial begin
    tick(2);
    chk("R1 rdata in reset", cfg_rdata, 8'h00);
    chk("R1 gnt in reset", {tmo_pulse, gnt}, 0);
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    tick(1);
    chk("R1 after release", {cfg_rdata, 3'b0, tmo_pulse, gnt}, 0);

    // R3 priority table
    foreach (PVEC[i]) begin
      req = 4'h0; tick(1);
      req = PVEC[i][7:4]; tick(1);
      chk("R3 priority", gnt, PVEC[i][3:0]);
    end
    // R3 hold
    req = 4'h0; tick(1);
    req = 4'b0100; tick(1);
    req = 4'b0101; tick(1);
    chk("R3 held grant", gnt, 4'b0100);
    req = 4'b0001; tick(1);
    chk("R3 regrant", gnt, 4'b0001);

    // R2 reserved bits
    wr(8'hFF);
    chk("R2 reserved read zero", cfg_rdata, 8'hC1);
    wr(8'h00);
    chk("R2 write zero", cfg_rdata, 8'h00);

    // R4 mask
    req = 4'h0; tick(1);
    wr(8'h01);
    req = 4'b0001; tick(2);
    chk("R4 masked ignored", gnt, 4'b0000);
    req = 4'b0101; tick(1);
    chk("R4 next request", gnt, 4'b0100);
    req = 4'h0; tick(1);

    // R5 disabled time-out
    wr(8'h00);
    bus_idle = 1'b1;
    req = 4'b0010; tick(1);
    begin
      int pulses = 0;
      for (int k = 0; k < 40; k++) begin tick(1); if (tmo_pulse) pulses++; end
      chk("R5 no pulse", pulses, 0);
    end
    chk("R5 grant kept", gnt, 4'b0010);

    // R6/R10 time-out on master 1
    req = 4'h0; tick(1);
    wr(8'h80);
    req = 4'b0010; tick(1);
    chk("R6 granted", gnt, 4'b0010);
    await_tmo("R6", 4'b0010);
    tick(1);
    chk("R10 rearbitrate", {27'd0, tmo_pulse, gnt}, 32'h02);
    chk("R6 pulse single", tmo_pulse, 0);

    // R7 window restart by FRAME
    tick(9);
    frame_act = 1'b1; tick(1); frame_act = 1'b0;
    await_tmo("R7 frame", 4'b0010);
    tick(1);
    tick(5);
    bus_idle = 1'b0; tick(1); bus_idle = 1'b1;
    await_tmo("R7 busy", 4'b0010);

    // R8 non-zero master does not touch mask
    req = 4'h0; tick(1);
    wr(8'hC0);
    req = 4'b0010; tick(1);
    await_tmo("R8 m1", 4'b0010);
    chk("R8 m1 no mask", cfg_rdata, 8'hC0);
    // R8 master 0 masked
    req = 4'h0; tick(2);
    req = 4'b0001; tick(1);
    chk("R8 m0 granted", gnt, 4'b0001);
    await_tmo("R8 m0", 4'b0001);
    chk("R8 mask set", cfg_rdata, 8'hC1);
    tick(2);
    chk("R8 masked after", gnt, 4'b0000);

    // R9 same-cycle write and auto mask
    wr(8'hC0);
    tick(1);
    chk("R9 regrant m0", gnt, 4'b0001);
    tick(15);
    cfg_we = 1'b1; cfg_wdata = 8'hC0;
    tick(1);
    cfg_we = 1'b0;
    chk("R9 mask wins", cfg_rdata, 8'hC1);
    chk("R9 dropped", {tmo_pulse, gnt}, 5'h10);
    wr(8'h40);
    tick(1);
    chk("R9 cleared regrant", gnt, 4'b0001);

    // R11 light reset
    wr(8'h81);
    req = 4'b0010; tick(1);
    chk("R11 pre", gnt, 4'b0010);
    sys_rst_n = 1'b0; tick(1);
    chk("R11 gnt cleared", {tmo_pulse, gnt}, 0);
    chk("R11 reg kept", cfg_rdata, 8'h81);
    req = 4'h0; sys_rst_n = 1'b1; tick(1);
    req = 4'b0010; tick(1);
    await_tmo("R11 fresh window", 4'b0010);

    // R1 fundamental reset via second source
    rst_b_n = 1'b0; tick(1);
    chk("R1 rst_b clears", {cfg_rdata, 3'b0, tmo_pulse, gnt}, 0);
    rst_b_n = 1'b1; req = 4'h0; tick(1);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule